// File: doc/BRIEF.md
# Command-Queue Interrupt Status Register

This block holds the interrupt status word of a command-queuing storage host controller. Four event sources are captured into sticky status bits: halt complete, task complete, response error detected and task cleared. An event is captured only while its matching enable input is high. The captured bits drive a single registered interrupt line toward the processor.

Software reaches the word through a small APB-style register port at byte offset 0x10. Reads are combinational and have no side effects. Writes use a write-zero-to-clear rule. A status bit that receives a 0 is cleared. A status bit that receives a 1 keeps its value. This is the reverse of the common write-one-to-clear convention.

The halt-complete bit does not take a pulse. It watches a halt-state level and sets on the cycle after that level goes from low to high. Task complete has two sources: the completion of a task marked to interrupt, and a coalescing interrupt request. Task cleared also has two sources: completion of a clear of all tasks, and completion of a clear of one task.

Top module: `cq_irq_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every status bit reads 0 and irq is 0.
- R2: The status word answers only at byte address 0x10. Reads of any other address return 0, and writes to any other address change no status bit.
- R3: An event whose enable bit (evt_en[i]) is 0 leaves its status bit unchanged.
- R4: An enabled event sets its status bit at the next clock edge, and the bit stays 1 until software clears it. The bit positions are: bit 0 halt complete, bit 1 task complete, bit 2 response error, bit 3 task cleared.
- R5: A write to address 0x10 with data bit i equal to 0 clears status bit i at the next clock edge.
- R6: A write to address 0x10 with data bit i equal to 1 leaves status bit i unchanged.
- R7: Status bit 0 sets when halt_state goes from 0 to 1. Holding halt_state at 1 does not set the bit again after software has cleared it.
- R8: Status bit 1 sets on task_int_done or on coal_int.
- R9: Status bit 3 sets on clr_all_done or on clr_one_done.
- R10: When an enabled event and a write of 0 hit the same bit in the same cycle, the bit ends at 1.
- R11: irq is a registered OR of the status bits. It follows the status word one clock later.
- R12: Bits 31:4 always read 0, and writes to them have no effect.
- R13: A read (psel high, pwrite low) returns the current status with no wait state and does not change any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a write |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address inside the command-queue register block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data; combinational, and 0 when the access is not a read of offset 0x10 |
| halt_state | input | 1 | Level that is high while the queue engine is halted |
| task_int_done | input | 1 | Pulse: a task marked to interrupt completed |
| coal_int | input | 1 | Pulse: the coalescing logic requests an interrupt |
| resp_err | input | 1 | Pulse: an error was found in a device response |
| clr_all_done | input | 1 | Pulse: a clear of all tasks completed |
| clr_one_done | input | 1 | Pulse: a clear of one task completed |
| evt_en | input | 4 | Per-bit capture enables, in the same bit order as the status word |
| irq | output | 1 | Interrupt request |

## Verification
A wrong stored bit appears on prdata in the same cycle a read is issued. It also appears on irq exactly one edge after the status flop changes. The bench therefore reads back after every edge and can name the cycle in which a bit went wrong. A halt-edge register that has lost its state shows up as a missing or duplicated halt-complete bit on the first read after halt_state rises or is held. A wrong priority between setting and clearing shows up only on the read that follows a coincident event and clearing write, which is why the bench drives that case on purpose.

// File: rtl/cqis_pkg.sv
// Package: shared constants for the command-queue interrupt status block.
// Assumes byte addressing inside a 4 KiB register window.
package cqis_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned NUM_SRC    = 4;
    localparam logic [11:0] STATUS_OFS = 12'h010;

    // Bit positions inside the status word.
    typedef enum int unsigned {
        SRC_HALT      = 0,
        SRC_TASK_DONE = 1,
        SRC_RESP_ERR  = 2,
        SRC_TASK_CLR  = 3
    } src_e;
endpackage

// File: rtl/cqis_level_rise.sv
// Module: cqis_level_rise
// Turns a level into a one-cycle pulse when it goes from 0 to 1.
// Assumes the level is already synchronous to clk. The registered copy
// resets to 0, so a level that is high when reset ends counts as a rise.
module cqis_level_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    // Keep last cycle's value of the level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    // Pulse high only in the first cycle the level is seen high.
    always_comb rise_o = level_i & ~level_q;

    // R7: a rise pulse can never be followed directly by another one.
    a_r7_single_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/cqis_status_bank.sv
// Module: cqis_status_bank
// A bank of sticky status bits. Each bit sets on an enabled event and
// clears when software writes 0 to it. A set beats a clear in the same
// cycle, so no event is lost. Assumes wr_hit_i is a single-cycle strobe.
module cqis_status_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] en_i,
    input  logic         wr_hit_i,
    input  logic [N-1:0] wr_bits_i,
    output logic [N-1:0] status_o
);
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;

    // An event counts only when its enable bit is high.
    always_comb set_vec = evt_i & en_i;

    // A write clears exactly the bits that are written as 0.
    always_comb clr_vec = wr_hit_i ? ~wr_bits_i : '0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Sticky bit: set wins, otherwise clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)          status_o[i] <= 1'b0;
            else if (set_vec[i]) status_o[i] <= 1'b1;
            else if (clr_vec[i]) status_o[i] <= 1'b0;
        end

        // R4 and R10: an enabled event always leaves the bit set.
        a_r4_enabled_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && en_i[i]) |=> status_o[i]);

        // R3: with no enabled event and no prior value, the bit stays clear.
        a_r3_disabled_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (!status_o[i] && !(evt_i[i] && en_i[i])) |=> !status_o[i]);

        // R5: a written 0 clears the bit when no event competes.
        a_r5_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit_i && !wr_bits_i[i] && !(evt_i[i] && en_i[i])) |=> !status_o[i]);

        // R6: a written 1 keeps the old value when no event competes.
        a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit_i && wr_bits_i[i] && !(evt_i[i] && en_i[i])) |=> $stable(status_o[i]));
    end
endmodule

// File: rtl/cqis_regport.sv
// Module: cqis_regport
// Decodes the APB-style port for the status word. It produces the write
// strobe and data for the status bank and the combinational read data.
// Assumes no wait states: a write takes effect in the access phase.
module cqis_regport #(
    parameter int unsigned       ADDR_W = 12,
    parameter int unsigned       DATA_W = 32,
    parameter int unsigned       N      = 4,
    parameter logic [ADDR_W-1:0] OFS    = 12'h010
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [N-1:0]      status_i,
    output logic              wr_hit_o,
    output logic [N-1:0]      wr_bits_o,
    output logic [DATA_W-1:0] prdata
);
    localparam int unsigned PAD_W = DATA_W - N;

    logic addr_hit;

    // Match the status word's byte offset.
    always_comb addr_hit = (paddr == OFS);

    // Write strobe in the access phase; upper data bits are dropped.
    always_comb begin
        wr_hit_o  = psel & penable & pwrite & addr_hit;
        wr_bits_o = pwdata[N-1:0];
    end

    // Zero-wait read of the status word, with the reserved bits padded to 0.
    always_comb prdata = (psel & ~pwrite & addr_hit) ? {{PAD_W{1'b0}}, status_i} : '0;
endmodule

// File: rtl/cq_irq_status.sv
// Module: cq_irq_status (top)
// Interrupt status word for a command-queuing storage host controller.
// It maps the event inputs onto four sticky bits and decodes the register
// port. It drives a registered interrupt line as the OR of the bits.
// Assumes every input is synchronous to clk.
module cq_irq_status #(
    parameter int unsigned       ADDR_W = cqis_pkg::ADDR_W,
    parameter int unsigned       DATA_W = cqis_pkg::REG_W,
    parameter logic [ADDR_W-1:0] OFS    = cqis_pkg::STATUS_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              halt_state,
    input  logic              task_int_done,
    input  logic              coal_int,
    input  logic              resp_err,
    input  logic              clr_all_done,
    input  logic              clr_one_done,
    input  logic [cqis_pkg::NUM_SRC-1:0] evt_en,
    output logic              irq
);
    import cqis_pkg::*;
    localparam int unsigned N = NUM_SRC;

    logic         halt_rise;
    logic [N-1:0] evt_vec;
    logic [N-1:0] status;
    logic         wr_hit;
    logic [N-1:0] wr_bits;

    cqis_level_rise u_halt_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (halt_state),
        .rise_o  (halt_rise)
    );

    // Gather the raw event sources into one vector in status-bit order.
    always_comb begin
        evt_vec                = '0;
        evt_vec[SRC_HALT]      = halt_rise;
        evt_vec[SRC_TASK_DONE] = task_int_done | coal_int;
        evt_vec[SRC_RESP_ERR]  = resp_err;
        evt_vec[SRC_TASK_CLR]  = clr_all_done | clr_one_done;
    end

    cqis_regport #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N      (N),
        .OFS    (OFS)
    ) u_regport (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .status_i  (status),
        .wr_hit_o  (wr_hit),
        .wr_bits_o (wr_bits),
        .prdata    (prdata)
    );

    cqis_status_bank #(.N(N)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_vec),
        .en_i      (evt_en),
        .wr_hit_i  (wr_hit),
        .wr_bits_i (wr_bits),
        .status_o  (status)
    );

    // Register the OR of all status bits onto the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |status;
    end

    // R11: irq shows the status word of the previous cycle.
    a_r11_irq_follows_status: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|$past(status))));

    // R13: a read with no event pending leaves the status word unchanged.
    a_r13_read_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && !(|(evt_vec & evt_en))) |=> $stable(status));

    // R2: a write to a different address does not clear any bit.
    a_r2_other_addr_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && (paddr != OFS)) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: tb/test_cq_irq_status.sv
// Bench for cq_irq_status: a vector table walked by one loop, then
// directed tests for reset, address decode, reserved bits and irq timing.
module test_cq_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        halt_state = 1'b0;
    logic        task_int_done = 1'b0, coal_int = 1'b0, resp_err = 1'b0;
    logic        clr_all_done = 1'b0, clr_one_done = 1'b0;
    logic [3:0]  evt_en = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    cq_irq_status i_cq_irq_status (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .halt_state(halt_state),
        .task_int_done(task_int_done), .coal_int(coal_int), .resp_err(resp_err),
        .clr_all_done(clr_all_done), .clr_one_done(clr_one_done),
        .evt_en(evt_en), .irq(irq)
    );

    // Vector: [18] halt level, [17:13] {task_int, coal, resp, clr_all, clr_one},
    // [12:9] enables, [8] write, [7:4] write data, [3:0] expected status.
    localparam int NV = 18;
    localparam logic [18:0] VEC [0:NV-1] = '{
        {1'b0, 5'b00000, 4'hF, 1'b0, 4'h0, 4'h0},  // idle
        {1'b0, 5'b10000, 4'h0, 1'b0, 4'h0, 4'h0},  // R3 disabled task complete
        {1'b0, 5'b10000, 4'hF, 1'b0, 4'h0, 4'h2},  // R4 R8 task_int
        {1'b0, 5'b00000, 4'hF, 1'b1, 4'hF, 4'h2},  // R6 write ones
        {1'b0, 5'b00000, 4'hF, 1'b1, 4'hD, 4'h0},  // R5 clear bit 1
        {1'b0, 5'b01000, 4'hF, 1'b0, 4'h0, 4'h2},  // R8 coalescing
        {1'b0, 5'b00100, 4'hF, 1'b0, 4'h0, 4'h6},  // R4 response error
        {1'b0, 5'b00010, 4'hF, 1'b0, 4'h0, 4'hE},  // R9 clear all
        {1'b0, 5'b00000, 4'hF, 1'b1, 4'h0, 4'h0},  // R5 clear everything
        {1'b0, 5'b00001, 4'h8, 1'b0, 4'h0, 4'h8},  // R9 clear one
        {1'b1, 5'b00000, 4'hF, 1'b0, 4'h0, 4'h9},  // R7 halt rise
        {1'b1, 5'b00000, 4'hF, 1'b1, 4'h8, 4'h8},  // R5 clear halt bit
        {1'b1, 5'b00000, 4'hF, 1'b0, 4'h0, 4'h8},  // R7 held level, no re-set
        {1'b0, 5'b00000, 4'hF, 1'b0, 4'h0, 4'h8},  // halt falls
        {1'b1, 5'b00000, 4'h7, 1'b0, 4'h0, 4'h9},  // R7 second rise
        {1'b1, 5'b00100, 4'hB, 1'b0, 4'h0, 4'h9},  // R3 response error disabled
        {1'b1, 5'b10000, 4'hF, 1'b1, 4'h0, 4'h2},  // R10 set beats clear
        {1'b1, 5'b00000, 4'hF, 1'b1, 4'h0, 4'h0}   // clear all
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_read(input logic [11:0] a);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; pwdata = '0;
    endtask

    task automatic drive_write(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    endtask

    task automatic clear_events();
        task_int_done = 1'b0; coal_int = 1'b0; resp_err = 1'b0;
        clr_all_done = 1'b0; clr_one_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive_read(12'h010);
        #1;
        chk("R1 status after reset", prdata, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            halt_state    = VEC[v][18];
            task_int_done = VEC[v][17];
            coal_int      = VEC[v][16];
            resp_err      = VEC[v][15];
            clr_all_done  = VEC[v][14];
            clr_one_done  = VEC[v][13];
            evt_en        = VEC[v][12:9];
            if (VEC[v][8]) drive_write(12'h010, {28'hFFFFFFF, VEC[v][7:4]});
            else           drive_read(12'h010);
            @(posedge clk);
            #1;
            clear_events();
            drive_read(12'h010);
            #1;
            chk($sformatf("R4/R5/R6/R7 vector %0d", v), prdata, {28'h0, VEC[v][3:0]});
        end

        // R11: irq lags the status word by one edge.
        @(negedge clk);
        evt_en = 4'hF; resp_err = 1'b1;
        @(posedge clk); #1; clear_events(); drive_read(12'h010); #1;
        chk("R11 status set", prdata, 32'h4);
        chk("R11 irq not yet high", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        chk("R11 irq high", {31'b0, irq}, 32'h1);

        // R13: repeated reads leave the value intact.
        repeat (3) @(posedge clk);
        #1;
        chk("R13 read no side effect", prdata, 32'h4);

        // R2: another address reads 0, and a write of 0 there clears nothing.
        drive_read(12'h014); #1;
        chk("R2 other address reads zero", prdata, 32'h0);
        @(negedge clk);
        drive_write(12'h014, 32'h0);
        @(posedge clk); #1; drive_read(12'h010); #1;
        chk("R2 write elsewhere ignored", prdata, 32'h4);

        // R12: writing ones to the reserved bits leaves them reading 0.
        @(negedge clk);
        drive_write(12'h010, 32'hFFFF_FFFF);
        @(posedge clk); #1; drive_read(12'h010); #1;
        chk("R12 reserved bits read zero", prdata, 32'h4);

        // R5 with R11: a clear drops irq one edge later.
        @(negedge clk);
        drive_write(12'h010, 32'hFFFF_FFF0);
        @(posedge clk); #1; drive_read(12'h010); #1;
        chk("R5 cleared", prdata, 32'h0);
        chk("R11 irq still high", {31'b0, irq}, 32'h1);
        @(posedge clk); #1;
        chk("R11 irq low", {31'b0, irq}, 32'h0);

        // R9 and R1: set a bit, then reset in mid-run.
        @(negedge clk);
        clr_one_done = 1'b1;
        @(posedge clk); #1; clear_events();
        @(posedge clk); #1;
        chk("R11 irq from task cleared", {31'b0, irq}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid-run reset status", prdata, 32'h0);
        chk("R1 mid-run reset irq", {31'b0, irq}, 32'h0);

        finish_run();
    end
endmodule